// File: doc/BRIEF.md
# Packet Memory Pointer and Data Port

This block lets a host reach individual bytes and words of buffered packets without mapping the whole packet RAM into its address space. The host programs a pointer register with a byte offset into a packet and three flags. One flag decides which packet is meant: the packet at the head of the receive queue, or the one held in a host-written packet-number register. A second flag lets the offset step forward on its own after each data access. A third flag marks the pointer as set up for reading.

The host then moves data through a single data register. Byte and word reads and writes on that register become accesses to a synchronous 16-bit packet RAM. The RAM has byte enables and sits outside the block. The physical byte address is the packet number times 256 plus the 11-bit offset.

Reads are served from a one-word prefetch buffer. The buffer is filled when the pointer is written in read mode, and again after every data read. The host waits on a ready flag while a fill is in flight. Packets keep their usual layout: a status word at offset 0, a byte count at offset 2 (low 11 bits used), and a control byte in the last word whose bit 5 flags an odd length and whose bit 4 asks for CRC on transmit. The port itself moves bytes and gives no field any special treatment.

Top module: `pm_data_port`

## Requirements
- R1: After reset the pointer and packet-number registers read back 0, host_ready_o is 1, and ram_re_o and ram_we_o are 0.
- R2: A pointer write stores bit 15 (receive select), bit 14 (auto-advance), bit 13 (read mode) and bits 10:0 (offset). Reading the pointer register (host_sel_i = 0) returns these bits with bits 12:11 as 0.
- R3: With bit 15 of the pointer set, the packet number is rx_head_i. With it clear, the packet number is the packet-number register, written at host_sel_i = 1 from host_wdata_i[PNUM_W-1:0].
- R4: The byte address is (packet number × 256 + offset) modulo 2^(PNUM_W+8). ram_addr_o carries this address shifted right by one.
- R5: A word write (host_byte_i = 0) drives ram_be_o = 2'b11 with host_wdata_i. Bits 7:0 go to the even byte, and offset bit 0 is ignored.
- R6: A byte write (host_byte_i = 1) enables one lane only. Offset bit 0 = 0 selects ram_be_o = 2'b01 (bits 7:0), and 1 selects 2'b10 (bits 15:8). In both cases host_wdata_i[7:0] is the data.
- R7: When auto-advance is set, each data access adds 1 to the offset for a byte access and 2 for a word access, wrapping within 11 bits. When auto-advance is clear, the offset is unchanged.
- R8: A pointer write with bit 13 set issues a RAM read in the next cycle. host_ready_o stays low until the word has been captured.
- R9: A data read returns the prefetched word, or for a byte read the lane picked by offset bit 0, zero-extended. It then refetches at the updated offset.
- R10: Data selects 2 and 3 (the second byte lane address) behave identically.
- R11: A pointer write with bit 13 clear issues no RAM read and leaves host_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_sel_i | input | 2 | 0 pointer, 1 packet number, 2/3 data |
| host_byte_i | input | 1 | 1 = byte access, 0 = word access |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data |
| host_ready_o | output | 1 | No prefetch in flight |
| rx_head_i | input | PNUM_W | Packet number at the receive queue head |
| ram_addr_o | output | PNUM_W+7 | RAM word address |
| ram_re_o | output | 1 | RAM read strobe, data one cycle later |
| ram_we_o | output | 1 | RAM write strobe |
| ram_be_o | output | 2 | RAM byte enables |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data |

## Verification
The assertions assume the host issues data accesses and pointer writes only while host_ready_o is high. They also assume it never raises read and write together. Under those assumptions a fill never overlaps a write, and the offset moves only on the access that caused it. The bench keeps to these rules: every host task waits for ready before it returns, and it drives exactly one strobe per access. Read checks also assume no data write has happened since the last fill, so every read scenario reprograms the pointer after writing.

// File: rtl/pktmem_pkg.sv
package pktmem_pkg;
  localparam int OFFS_W      = 11;
  localparam int PTR_RX_BIT  = 15;
  localparam int PTR_INC_BIT = 14;
  localparam int PTR_RD_BIT  = 13;

  typedef enum logic [1:0] {
    SEL_PTR     = 2'd0,
    SEL_PNR     = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_DATA_HI = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic              rx_sel;
    logic              auto_inc;
    logic              rd_mode;
    logic [OFFS_W-1:0] offs;
  } ptr_t;
endpackage

// File: rtl/pm_ptr_reg.sv
module pm_ptr_reg
  import pktmem_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ptr_we_i,
  input  logic [15:0] ptr_wdata_i,
  input  logic        adv_i,
  input  logic        adv_byte_i,
  output ptr_t        ptr_o
);
  localparam logic [OFFS_W-1:0] STEP_BYTE = OFFS_W'(1);
  localparam logic [OFFS_W-1:0] STEP_WORD = OFFS_W'(2);

  ptr_t ptr_q;
  logic unused_bits;
  assign unused_bits = ^ptr_wdata_i[PTR_RD_BIT-1:OFFS_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_we_i) begin
      ptr_q.rx_sel   <= ptr_wdata_i[PTR_RX_BIT];
      ptr_q.auto_inc <= ptr_wdata_i[PTR_INC_BIT];
      ptr_q.rd_mode  <= ptr_wdata_i[PTR_RD_BIT];
      ptr_q.offs     <= ptr_wdata_i[OFFS_W-1:0];
    end else if (adv_i) begin
      ptr_q.offs <= ptr_q.offs + (adv_byte_i ? STEP_BYTE : STEP_WORD);
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pm_addr_gen.sv
module pm_addr_gen
  import pktmem_pkg::*;
#(
  parameter int PNUM_W     = 4,
  parameter int PAGE_SHIFT = 8,
  localparam int ADDR_W    = PNUM_W + PAGE_SHIFT
) (
  input  ptr_t              ptr_i,
  input  logic [PNUM_W-1:0] rx_head_i,
  input  logic [PNUM_W-1:0] pnr_i,
  output logic [ADDR_W-1:0] byte_addr_o
);
  logic [PNUM_W-1:0] pnum;
  logic [ADDR_W-1:0] page_base;
  logic [ADDR_W-1:0] offs_ext;

  assign pnum      = ptr_i.rx_sel ? rx_head_i : pnr_i;
  assign page_base = {pnum, {PAGE_SHIFT{1'b0}}};

  generate
    if (ADDR_W >= OFFS_W) begin : g_wide
      assign offs_ext = {{(ADDR_W-OFFS_W){1'b0}}, ptr_i.offs};
    end else begin : g_narrow
      assign offs_ext = ptr_i.offs[ADDR_W-1:0];
    end
  endgenerate

  // modulo the RAM size: carry out is dropped
  assign byte_addr_o = page_base + offs_ext;
endmodule

// File: rtl/pm_fetch_buf.sv
module pm_fetch_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              busy_o
);
  logic              req_q;
  logic              cap_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      cap_q <= 1'b0;
      buf_q <= '0;
    end else begin
      req_q <= fetch_i;
      cap_q <= req_q;
      if (cap_q) buf_q <= ram_rdata_i;
    end
  end

  assign ram_re_o = req_q;
  assign buf_o    = buf_q;
  assign busy_o   = req_q | cap_q;
endmodule

// File: rtl/pm_data_port.sv
module pm_data_port
  import pktmem_pkg::*;
#(
  parameter int PNUM_W     = 4,
  parameter int PAGE_SHIFT = 8,
  localparam int ADDR_W    = PNUM_W + PAGE_SHIFT,
  localparam int WADDR_W   = ADDR_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic               host_rd_i,
  input  logic [1:0]         host_sel_i,
  input  logic               host_byte_i,
  input  logic [15:0]        host_wdata_i,
  output logic [15:0]        host_rdata_o,
  output logic               host_ready_o,
  input  logic [PNUM_W-1:0]  rx_head_i,
  output logic [WADDR_W-1:0] ram_addr_o,
  output logic               ram_re_o,
  output logic               ram_we_o,
  output logic [1:0]         ram_be_o,
  output logic [15:0]        ram_wdata_o,
  input  logic [15:0]        ram_rdata_i
);
  host_sel_e         sel;
  ptr_t              ptr_q;
  logic [PNUM_W-1:0] pnr_q;
  logic [ADDR_W-1:0] byte_addr;
  logic [15:0]       buf_word;
  logic              busy;
  logic              is_data, ptr_we, pnr_we, data_wr, data_rd, fetch, lane;
  logic              auto_inc_q;
  logic [OFFS_W-1:0] offs_q;

  assign sel        = host_sel_e'(host_sel_i);
  assign is_data    = (sel == SEL_DATA) || (sel == SEL_DATA_HI);
  assign ptr_we     = host_wr_i && (sel == SEL_PTR);
  assign pnr_we     = host_wr_i && (sel == SEL_PNR);
  assign data_wr    = host_wr_i && is_data;
  assign data_rd    = host_rd_i && is_data;
  assign fetch      = (ptr_we && host_wdata_i[PTR_RD_BIT]) || data_rd;
  assign auto_inc_q = ptr_q.auto_inc;
  assign offs_q     = ptr_q.offs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pnr_q <= '0;
    else if (pnr_we) pnr_q <= host_wdata_i[PNUM_W-1:0];
  end

  pm_ptr_reg u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ptr_we_i    (ptr_we),
    .ptr_wdata_i (host_wdata_i),
    .adv_i       ((data_wr || data_rd) && ptr_q.auto_inc),
    .adv_byte_i  (host_byte_i),
    .ptr_o       (ptr_q)
  );

  pm_addr_gen #(.PNUM_W(PNUM_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .ptr_i       (ptr_q),
    .rx_head_i   (rx_head_i),
    .pnr_i       (pnr_q),
    .byte_addr_o (byte_addr)
  );

  pm_fetch_buf #(.DATA_W(16)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_i     (fetch),
    .ram_rdata_i (ram_rdata_i),
    .ram_re_o    (ram_re_o),
    .buf_o       (buf_word),
    .busy_o      (busy)
  );

  assign lane         = byte_addr[0];
  assign ram_addr_o   = byte_addr[ADDR_W-1:1];
  assign ram_we_o     = data_wr;
  assign ram_be_o     = host_byte_i ? (lane ? 2'b10 : 2'b01) : 2'b11;
  assign ram_wdata_o  = host_byte_i ? {2{host_wdata_i[7:0]}} : host_wdata_i;
  assign host_ready_o = !busy;

  always_comb begin
    unique case (sel)
      SEL_PTR: host_rdata_o = {ptr_q.rx_sel, ptr_q.auto_inc, ptr_q.rd_mode,
                               {(PTR_RD_BIT-OFFS_W){1'b0}}, ptr_q.offs};
      SEL_PNR: host_rdata_o = {{(16-PNUM_W){1'b0}}, pnr_q};
      default: begin
        if (!host_byte_i) host_rdata_o = buf_word;
        else if (lane)    host_rdata_o = {8'h00, buf_word[15:8]};
        else              host_rdata_o = {8'h00, buf_word[7:0]};
      end
    endcase
  end
endmodule

// File: rtl/pm_data_port_chk.sv
module pm_data_port_chk #(
  parameter int OFFS_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [1:0]        host_sel_i,
  input logic              host_byte_i,
  input logic              wdata_rd_bit,
  input logic              host_ready_o,
  input logic              ram_re_o,
  input logic              ram_we_o,
  input logic [1:0]        ram_be_o,
  input logic              auto_inc_q,
  input logic [OFFS_W-1:0] offs_q
);
  logic data_acc;
  assign data_acc = host_ready_o && (host_wr_i ^ host_rd_i) && host_sel_i[1];

  // R8
  ptr_rd_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_ready_o && host_wr_i && host_sel_i == 2'd0 && wdata_rd_bit) |=> ram_re_o);

  // R11
  ptr_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_ready_o && host_wr_i && !host_rd_i && host_sel_i == 2'd0 && !wdata_rd_bit)
      |=> (!ram_re_o && host_ready_o));

  // R8
  fetch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> !host_ready_o);

  // R6
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && host_byte_i) |-> ($countones(ram_be_o) == 1));

  // R5
  word_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !host_byte_i) |-> (ram_be_o == 2'b11));

  // R7
  no_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && !auto_inc_q) |=> $stable(offs_q));

  // R7
  byte_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && auto_inc_q && host_byte_i) |=> (offs_q == $past(offs_q) + OFFS_W'(1)));

  // R7
  word_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && auto_inc_q && !host_byte_i) |=> (offs_q == $past(offs_q) + OFFS_W'(2)));
endmodule

bind pm_data_port pm_data_port_chk #(.OFFS_W(pktmem_pkg::OFFS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_sel_i   (host_sel_i),
  .host_byte_i  (host_byte_i),
  .wdata_rd_bit (host_wdata_i[13]),
  .host_ready_o (host_ready_o),
  .ram_re_o     (ram_re_o),
  .ram_we_o     (ram_we_o),
  .ram_be_o     (ram_be_o),
  .auto_inc_q   (auto_inc_q),
  .offs_q       (offs_q)
);

// File: tb/pm_data_port_tb.sv
module pm_data_port_tb;
  localparam int PNUM_W  = 4;
  localparam int WADDR_W = PNUM_W + 7;
  localparam int WORDS   = 1 << WADDR_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               host_wr = 1'b0, host_rd = 1'b0, host_byte = 1'b0;
  logic [1:0]         host_sel = 2'd0;
  logic [15:0]        host_wdata = '0;
  logic [15:0]        host_rdata;
  logic               host_ready;
  logic [PNUM_W-1:0]  rx_head = '0;
  logic [WADDR_W-1:0] ram_addr;
  logic               ram_re, ram_we;
  logic [1:0]         ram_be;
  logic [15:0]        ram_wdata, ram_rdata;
  logic [15:0]        mem [WORDS];

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pm_data_port #(.PNUM_W(PNUM_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_sel_i(host_sel),
    .host_byte_i(host_byte), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .host_ready_o(host_ready), .rx_head_i(rx_head),
    .ram_addr_o(ram_addr), .ram_re_o(ram_re), .ram_we_o(ram_we),
    .ram_be_o(ram_be), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) begin
      if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
      if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
    end
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!host_ready) @(negedge clk);
  endtask

  task automatic hwr(input logic [1:0] sel, input logic byt, input logic [15:0] d);
    @(negedge clk);
    host_sel = sel; host_byte = byt; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    wait_ready();
  endtask

  task automatic hrd(input logic [1:0] sel, input logic byt, output logic [15:0] d);
    @(negedge clk);
    host_sel = sel; host_byte = byt; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
    wait_ready();
  endtask

  task automatic set_ptr(input bit rx, input bit inc, input bit rd, input logic [10:0] offs);
    hwr(2'd0, 1'b0, {rx, inc, rd, 2'b00, offs});
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(host_ready === 1'b1, "R1 ready", {15'd0, host_ready}, 16'd1);
    chk(ram_re === 1'b0 && ram_we === 1'b0, "R1 strobes", {14'd0, ram_re, ram_we}, 16'd0);
    hrd(2'd0, 1'b0, v); chk(v === 16'h0000, "R1 pointer", v, 16'h0000);
    hrd(2'd1, 1'b0, v); chk(v === 16'h0000, "R1 pnr", v, 16'h0000);
  endtask

  task automatic t_ptr_fields();
    logic [15:0] v;
    hwr(2'd0, 1'b0, 16'hFFFF);
    hrd(2'd0, 1'b0, v); chk(v === 16'hE7FF, "R2 all ones", v, 16'hE7FF);
    // R11: no fetch after a write-mode pointer write
    @(negedge clk);
    host_sel = 2'd0; host_wdata = 16'h1ABC; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk(ram_re === 1'b0 && host_ready === 1'b1, "R11 no fetch", {14'd0, ram_re, host_ready}, 16'd1);
    hrd(2'd0, 1'b0, v); chk(v === 16'h02BC, "R2 flags clear", v, 16'h02BC);
  endtask

  task automatic t_word();
    logic [15:0] v;
    hwr(2'd1, 1'b0, 16'h0003);
    set_ptr(1'b0, 1'b1, 1'b0, 11'd4);
    hwr(2'd2, 1'b0, 16'hBEEF);
    hwr(2'd2, 1'b0, 16'h1234);
    chk(mem[386] === 16'hBEEF, "R4 R5 word 0", mem[386], 16'hBEEF);
    chk(mem[387] === 16'h1234, "R5 word 1", mem[387], 16'h1234);
    hrd(2'd0, 1'b0, v); chk(v === 16'h4008, "R7 word step", v, 16'h4008);
    // R8: ready low right after a read-mode pointer write
    @(negedge clk);
    host_sel = 2'd0; host_wdata = {3'b011, 2'b00, 11'd4}; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk(host_ready === 1'b0, "R8 busy", {15'd0, host_ready}, 16'd0);
    wait_ready();
    hrd(2'd2, 1'b0, v); chk(v === 16'hBEEF, "R9 first word", v, 16'hBEEF);
    hrd(2'd2, 1'b0, v); chk(v === 16'h1234, "R9 refetch word", v, 16'h1234);
  endtask

  task automatic t_byte();
    logic [15:0] v;
    hwr(2'd1, 1'b0, 16'h0005);
    set_ptr(1'b0, 1'b1, 1'b0, 11'h010);
    hwr(2'd2, 1'b1, 16'h0011);
    hwr(2'd3, 1'b1, 16'h0022);
    chk(mem[648] === 16'h2211, "R6 R10 byte lanes", mem[648], 16'h2211);
    set_ptr(1'b0, 1'b1, 1'b1, 11'h010);
    hrd(2'd2, 1'b1, v); chk(v === 16'h0011, "R9 byte low", v, 16'h0011);
    hrd(2'd3, 1'b1, v); chk(v === 16'h0022, "R9 R10 byte high", v, 16'h0022);
    hrd(2'd0, 1'b0, v); chk(v === 16'h6012, "R7 byte steps", v, 16'h6012);
    set_ptr(1'b0, 1'b0, 1'b0, 11'h021);
    hwr(2'd2, 1'b0, 16'hCAFE);
    chk(mem[656] === 16'hCAFE, "R5 odd offset word", mem[656], 16'hCAFE);
    hrd(2'd0, 1'b0, v); chk(v === 16'h0021, "R7 no advance", v, 16'h0021);
  endtask

  task automatic t_rx_select();
    logic [15:0] v;
    rx_head = 4'd9;
    hwr(2'd1, 1'b0, 16'h0002);
    set_ptr(1'b1, 1'b0, 1'b0, 11'd6);
    hwr(2'd2, 1'b0, 16'hA5A5);
    set_ptr(1'b0, 1'b0, 1'b0, 11'd6);
    hwr(2'd2, 1'b0, 16'h5A5A);
    chk(mem[1155] === 16'hA5A5, "R3 rx page", mem[1155], 16'hA5A5);
    chk(mem[259] === 16'h5A5A, "R3 pnr page", mem[259], 16'h5A5A);
    set_ptr(1'b1, 1'b1, 1'b1, 11'd6);
    hrd(2'd2, 1'b0, v); chk(v === 16'hA5A5, "R3 rx read", v, 16'hA5A5);
    set_ptr(1'b0, 1'b1, 1'b1, 11'd6);
    hrd(2'd2, 1'b0, v); chk(v === 16'h5A5A, "R3 pnr read", v, 16'h5A5A);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    hwr(2'd1, 1'b0, 16'h0001);
    set_ptr(1'b0, 1'b1, 1'b0, 11'h7FF);
    hwr(2'd2, 1'b1, 16'h0077);
    chk(mem[1151][15:8] === 8'h77, "R4 top offset", {8'd0, mem[1151][15:8]}, 16'h0077);
    hrd(2'd0, 1'b0, v); chk(v === 16'h4000, "R7 offset wrap", v, 16'h4000);
    hwr(2'd2, 1'b0, 16'h9999);
    chk(mem[128] === 16'h9999, "R7 after wrap", mem[128], 16'h9999);
    hwr(2'd1, 1'b0, 16'h000F);
    set_ptr(1'b0, 1'b0, 1'b0, 11'h204);
    hwr(2'd2, 1'b0, 16'h4321);
    chk(mem[130] === 16'h4321, "R4 address wrap", mem[130], 16'h4321);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr_fields();
    t_word();
    t_byte();
    t_rx_select();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule